// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block decides when the chip may enter its power-down state and how it comes back out. Software arms power-down with a control bit. The block goes down only once the CPU also reports that it is sleeping. While down, it removes the enables of the high-speed crystal, the high-speed RC oscillator and the PLL, and it withdraws the system clock release. The enables of the low-speed crystal and the low-speed RC oscillator stay under software control throughout, so logic clocked from them keeps running.

Any bit of the asynchronous wake vector is brought through a two-flop synchronizer. A wake then sets a sticky status bit, which can raise an interrupt, and takes the block out of power-down. The arm bit clears itself at that point. When the settling delay is enabled, the block waits for 4096 strobes of the high-speed crystal or 16 strobes of the high-speed RC before it releases the system clock. Which source is counted depends on the clock source that software has marked as the system clock. The block runs on an always-on clock. The oscillator cycle strobes arrive already synchronized to that clock.

Top module: `pd_wake_sequencer`

## Requirements
- R1: Power-down (`pd_active_o`=1) begins on the clock edge after a cycle in which the block is running, the arm bit is 1 and `cpu_sleep` is 1. With only one of the two conditions present, the block keeps running.
- R2: The arm bit (control bit 0, read back on `armed_o`) is cleared by hardware on the edge at which the block leaves power-down because of a wake. This clear takes priority over a software write in the same cycle.
- R3: While in power-down, `hs_xtal_en_o`, `hs_rc_en_o`, `pll_en_o` and `sys_clk_release_o` are all 0, whatever the control bits hold. In every other state each of the three enables equals its control bit: bit 4 for the high-speed crystal, bit 5 for the high-speed RC and bit 6 for the PLL.
- R4: `ls_xtal_en_o` (control bit 7) and `ls_rc_en_o` (control bit 8) follow the control register in every state and are not changed by entering or leaving power-down.
- R5: When the delay bit (control bit 1) is 1, a wake moves the block into a settling state. The high-speed enables are restored there, and `sys_clk_release_o` rises on the edge that consumes the last required strobe. If the source bit (control bit 3) is 1, 4096 `xtal_tick` strobes are required; if it is 0, 16 `rc_tick` strobes are required.
- R6: When the delay bit is 0, `sys_clk_release_o` rises on the edge that follows the first cycle in which the synchronized wake is seen. The synchronized wake is the OR of the wake vector after two flops.
- R7: The status bit `wake_status_o` is set by any bit of the synchronized wake vector and holds until a write with `wr_addr`=1 and `wr_data[0]`=1. A wake in the same cycle as that write leaves the bit set.
- R8: `wake_irq_o` is 1 exactly when `wake_status_o` is 1 and the interrupt enable (control bit 2) is 1.
- R9: A wake that arrives while the block is running or settling only sets the status bit. It neither changes the state nor restarts the settling count.
- R10: A write with `wr_addr`=0 loads `wr_data[8:0]` into the control register. After reset the control register holds 0x120 (both RC oscillators enabled), the block is running, the status bit is 0 and `sys_clk_release_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0: control register, 1: status clear |
| wr_data | input | DATA_W | Write data |
| cpu_sleep | input | 1 | CPU reports sleep |
| wake_evt | input | NWAKE | Asynchronous wake sources |
| xtal_tick | input | 1 | One strobe per high-speed crystal cycle |
| rc_tick | input | 1 | One strobe per high-speed RC cycle |
| hs_xtal_en_o | output | 1 | High-speed crystal enable |
| hs_rc_en_o | output | 1 | High-speed RC enable |
| pll_en_o | output | 1 | PLL enable |
| ls_xtal_en_o | output | 1 | Low-speed crystal enable |
| ls_rc_en_o | output | 1 | Low-speed RC enable |
| sys_clk_release_o | output | 1 | System clock gates may run |
| pd_active_o | output | 1 | Block is in power-down |
| armed_o | output | 1 | Current arm bit |
| wake_status_o | output | 1 | Sticky wake status |
| wake_irq_o | output | 1 | Wake interrupt |

## Verification
Two functions can act on the same register in the same cycle, and the bench provokes both on purpose. First, it holds a status-clear write while a wake source is active, so that every cycle carries both a set and a clear; the status must stay 1. Second, it writes the control register with the arm bit still 1 on the very cycle the synchronized wake takes the block out of power-down; `armed_o` must read 0 afterwards. A behavioural model computes every output each cycle, and the bench compares the outputs on each falling edge. A difference in any single cycle is therefore reported.

// File: rtl/pdseq_pkg.sv
// Package: shared state type and control-field positions for the
// power-down sequencer. Assumes a 9-bit control register.
package pdseq_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOWN   = 2'd1,
        ST_SETTLE = 2'd2
    } pd_state_t;

    localparam int CTRL_W   = 9;
    localparam int B_ARM    = 0;
    localparam int B_DLY    = 1;
    localparam int B_IRQ    = 2;
    localparam int B_SRCX   = 3;
    localparam int B_HSX    = 4;
    localparam int B_HSR    = 5;
    localparam int B_PLL    = 6;
    localparam int B_LSX    = 7;
    localparam int B_LSR    = 8;
    localparam logic [CTRL_W-1:0] CTRL_RST = 9'h120;
endpackage

// File: rtl/pdseq_wake_sync.sv
// Two-flop synchronizer for the asynchronous wake vector, followed by an
// OR reduction. Assumes that every wake source stays high for at least two
// clock cycles.
module pdseq_wake_sync #(
    parameter int NWAKE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWAKE-1:0] evt_async,
    output logic             evt_any
);
    logic [NWAKE-1:0] meta_q;
    logic [NWAKE-1:0] sync_q;

    // Two flop stages per wake bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= evt_async;
            sync_q <= meta_q;
        end
    end

    // Any synchronized wake source.
    assign evt_any = |sync_q;
endmodule

// File: rtl/pdseq_regs.sv
// Holds the control register and the sticky wake status. A hardware clear
// of the arm bit takes priority over a software write, and a wake set takes
// priority over a status-clear write.
module pdseq_regs #(
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          wake_any,
    input  logic                          hw_arm_clr,
    output logic [pdseq_pkg::CTRL_W-1:0]  ctrl,
    output logic                          status
);
    import pdseq_pkg::*;

    logic ctrl_wr;
    logic stat_clr;

    assign ctrl_wr  = wr_en && !wr_addr;
    assign stat_clr = wr_en && wr_addr && wr_data[0];

    // Control register: software load, then a hardware clear of the arm bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else begin
            if (ctrl_wr) ctrl <= wr_data[CTRL_W-1:0];
            if (hw_arm_clr) ctrl[B_ARM] <= 1'b0;
        end
    end

    // Sticky wake status: set wins over a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)        status <= 1'b0;
        else if (wake_any) status <= 1'b1;
        else if (stat_clr) status <= 1'b0;
    end
endmodule

// File: rtl/pdseq_fsm.sv
// Run / power-down / settle sequencer with the settling counter. Assumes
// that each strobe is high for one cycle per oscillator cycle.
module pdseq_fsm #(
    parameter int XTAL_SETTLE = 4096,
    parameter int RC_SETTLE   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arm,
    input  logic                  cpu_sleep,
    input  logic                  dly_en,
    input  logic                  src_xtal,
    input  logic                  wake_any,
    input  logic                  xtal_tick,
    input  logic                  rc_tick,
    output pdseq_pkg::pd_state_t  state,
    output logic                  arm_clr
);
    import pdseq_pkg::*;

    localparam int MAXC  = (XTAL_SETTLE > RC_SETTLE) ? XTAL_SETTLE : RC_SETTLE;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] XT_LAST = CNT_W'(XTAL_SETTLE - 1);
    localparam logic [CNT_W-1:0] RC_LAST = CNT_W'(RC_SETTLE - 1);

    logic [CNT_W-1:0] cnt;
    logic             sel_xtal;
    logic             tick;
    logic [CNT_W-1:0] last;

    assign tick    = sel_xtal ? xtal_tick : rc_tick;
    assign last    = sel_xtal ? XT_LAST : RC_LAST;
    assign arm_clr = (state == ST_DOWN) && wake_any;

    // State transitions and settle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            cnt      <= '0;
            sel_xtal <= 1'b0;
        end else begin
            case (state)
                ST_RUN: begin
                    if (arm && cpu_sleep) state <= ST_DOWN;
                end
                ST_DOWN: begin
                    if (wake_any) begin
                        if (dly_en) begin
                            state    <= ST_SETTLE;
                            cnt      <= '0;
                            sel_xtal <= src_xtal;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tick) begin
                        if (cnt == last) state <= ST_RUN;
                        else             cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pd_wake_sequencer.sv
// Top: power-down entry and wake sequencer. Gates the high-speed sources
// and the system clock in power-down and passes the low-speed enables
// through untouched. Assumes a single always-on clock and strobes that are
// already synchronized.
module pd_wake_sequencer #(
    parameter int DATA_W      = 16,
    parameter int NWAKE       = 8,
    parameter int XTAL_SETTLE = 4096,
    parameter int RC_SETTLE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cpu_sleep,
    input  logic [NWAKE-1:0]  wake_evt,
    input  logic              xtal_tick,
    input  logic              rc_tick,
    output logic              hs_xtal_en_o,
    output logic              hs_rc_en_o,
    output logic              pll_en_o,
    output logic              ls_xtal_en_o,
    output logic              ls_rc_en_o,
    output logic              sys_clk_release_o,
    output logic              pd_active_o,
    output logic              armed_o,
    output logic              wake_status_o,
    output logic              wake_irq_o
);
    import pdseq_pkg::*;

    logic              wake_any;
    logic              arm_clr;
    logic [CTRL_W-1:0] ctrl;
    logic              status;
    pd_state_t         state;
    logic              hs_allow;

    pdseq_wake_sync #(.NWAKE(NWAKE)) u_sync (
        .clk(clk), .rst_n(rst_n), .evt_async(wake_evt), .evt_any(wake_any)
    );

    pdseq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wake_any(wake_any), .hw_arm_clr(arm_clr),
        .ctrl(ctrl), .status(status)
    );

    pdseq_fsm #(.XTAL_SETTLE(XTAL_SETTLE), .RC_SETTLE(RC_SETTLE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(ctrl[B_ARM]), .cpu_sleep(cpu_sleep),
        .dly_en(ctrl[B_DLY]), .src_xtal(ctrl[B_SRCX]), .wake_any(wake_any),
        .xtal_tick(xtal_tick), .rc_tick(rc_tick), .state(state),
        .arm_clr(arm_clr)
    );

    // High-speed sources run in every state except power-down.
    assign hs_allow          = (state != ST_DOWN);
    assign hs_xtal_en_o      = ctrl[B_HSX] && hs_allow;
    assign hs_rc_en_o        = ctrl[B_HSR] && hs_allow;
    assign pll_en_o          = ctrl[B_PLL] && hs_allow;
    assign ls_xtal_en_o      = ctrl[B_LSX];
    assign ls_rc_en_o        = ctrl[B_LSR];
    assign sys_clk_release_o = (state == ST_RUN);
    assign pd_active_o       = (state == ST_DOWN);
    assign armed_o           = ctrl[B_ARM];
    assign wake_status_o     = status;
    assign wake_irq_o        = status && ctrl[B_IRQ];
endmodule

// File: rtl/pdseq_chk.sv
// Checker for pd_wake_sequencer, attached with bind. Works on ports only.
module pdseq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              cpu_sleep,
    input logic              hs_xtal_en_o,
    input logic              hs_rc_en_o,
    input logic              pll_en_o,
    input logic              ls_xtal_en_o,
    input logic              ls_rc_en_o,
    input logic              sys_clk_release_o,
    input logic              pd_active_o,
    input logic              armed_o,
    input logic              wake_status_o,
    input logic              wake_irq_o
);
    // R1
    entry_needs_arm_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_active_o) |-> ($past(cpu_sleep) && $past(armed_o)));

    // R3
    down_gates_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active_o |-> (!hs_xtal_en_o && !hs_rc_en_o && !pll_en_o && !sys_clk_release_o));

    // R2
    arm_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_active_o) |-> !armed_o);

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_status_o && !(wr_en && wr_addr && wr_data[0])) |=> wake_status_o);

    // R8
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq_o |-> wake_status_o);

    // R4
    low_speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(ls_xtal_en_o) && $stable(ls_rc_en_o)));
endmodule

bind pd_wake_sequencer pdseq_chk #(.DATA_W(DATA_W)) i_pdseq_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_sleep(cpu_sleep), .hs_xtal_en_o(hs_xtal_en_o),
    .hs_rc_en_o(hs_rc_en_o), .pll_en_o(pll_en_o), .ls_xtal_en_o(ls_xtal_en_o),
    .ls_rc_en_o(ls_rc_en_o), .sys_clk_release_o(sys_clk_release_o),
    .pd_active_o(pd_active_o), .armed_o(armed_o),
    .wake_status_o(wake_status_o), .wake_irq_o(wake_irq_o)
);

// File: tb/test_pd_wake_sequencer.sv
module test_pd_wake_sequencer;
    localparam int DATA_W = 16;
    localparam int NWAKE  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_addr = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              cpu_sleep = 1'b0;
    logic [NWAKE-1:0]  wake_evt = '0;
    logic              xtal_tick = 1'b0;
    logic              rc_tick = 1'b0;
    logic hs_xtal_en_o, hs_rc_en_o, pll_en_o, ls_xtal_en_o, ls_rc_en_o;
    logic sys_clk_release_o, pd_active_o, armed_o, wake_status_o, wake_irq_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    bit x_on   = 0;
    bit r_on   = 0;

    always #5 clk = ~clk;

    pd_wake_sequencer i_pd_wake_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_sleep(cpu_sleep), .wake_evt(wake_evt),
        .xtal_tick(xtal_tick), .rc_tick(rc_tick),
        .hs_xtal_en_o(hs_xtal_en_o), .hs_rc_en_o(hs_rc_en_o),
        .pll_en_o(pll_en_o), .ls_xtal_en_o(ls_xtal_en_o),
        .ls_rc_en_o(ls_rc_en_o), .sys_clk_release_o(sys_clk_release_o),
        .pd_active_o(pd_active_o), .armed_o(armed_o),
        .wake_status_o(wake_status_o), .wake_irq_o(wake_irq_o)
    );

    // Behavioural reference: 0 running, 1 down, 2 settling.
    int m_mode, m_cnt, m_need;
    int m_ctrl;
    bit m_stat;
    bit m_p1, m_p2;

    always @(posedge clk) begin
        bit seen;
        bit clr_arm;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_need = 0; m_ctrl = 'h120;
            m_stat = 0; m_p1 = 0; m_p2 = 0;
        end else begin
            seen    = m_p2;
            clr_arm = 0;
            m_p2 = m_p1;
            m_p1 = (wake_evt != 0);
            if (seen) m_stat = 1;
            else if (wr_en && wr_addr && wr_data[0]) m_stat = 0;
            if (m_mode == 0) begin
                if (m_ctrl[0] && cpu_sleep) m_mode = 1;
            end else if (m_mode == 1) begin
                if (seen) begin
                    clr_arm = 1;
                    if (m_ctrl[1]) begin
                        m_mode = 2; m_cnt = 0;
                        m_need = m_ctrl[3] ? 4096 : 16;
                        m_ctrl[30] = m_ctrl[3];
                    end else m_mode = 0;
                end
            end else begin
                if (m_ctrl[30] ? xtal_tick : rc_tick) begin
                    m_cnt++;
                    if (m_cnt == m_need) m_mode = 0;
                end
            end
            if (wr_en && !wr_addr) m_ctrl = (m_ctrl & 32'h4000_0000) | int'(wr_data[8:0]);
            if (clr_arm) m_ctrl[0] = 0;
        end
    end

    task automatic cmp(input string tag, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        cyc++;
        xtal_tick <= x_on;
        rc_tick   <= r_on && (cyc % 3 == 0);
        if (rst_n) begin
            cmp("R1 pd_active", pd_active_o, m_mode == 1);
            cmp("R3 hs_xtal_en", hs_xtal_en_o, m_ctrl[4] && m_mode != 1);
            cmp("R3 hs_rc_en", hs_rc_en_o, m_ctrl[5] && m_mode != 1);
            cmp("R3 pll_en", pll_en_o, m_ctrl[6] && m_mode != 1);
            cmp("R4 ls_xtal_en", ls_xtal_en_o, m_ctrl[7]);
            cmp("R4 ls_rc_en", ls_rc_en_o, m_ctrl[8]);
            cmp("R5 R6 release", sys_clk_release_o, m_mode == 0);
            cmp("R2 armed", armed_o, m_ctrl[0]);
            cmp("R7 status", wake_status_o, m_stat);
            cmp("R8 irq", wake_irq_o, m_stat && m_ctrl[2]);
        end
        if (cyc == 150000 && !done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit a, input int d);
        @(negedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = DATA_W'(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic wake_pulse(input int bitn, input int len);
        @(negedge clk); #1;
        wake_evt[bitn] = 1;
        repeat (len) @(negedge clk);
        #1 wake_evt = '0;
    endtask

    task automatic wait_release(input int lim);
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (sys_clk_release_o) break;
        end
    endtask

    initial begin
        idle(3);
        #1 rst_n = 1;
        idle(3);                     // R10 reset state checked by comparator
        // R4 R8 R10: xtal, PLL, low-speed xtal on, irq, delay, xtal source
        wr(0, 'h1DE);
        cpu_sleep = 1; idle(4);      // R1 sleep without arm: stays running
        cpu_sleep = 0;
        wr(0, 'h1DF); idle(4);       // R1 arm without sleep: stays running
        #1 cpu_sleep = 1; idle(4);   // R1 both: enter power-down (R3)
        cpu_sleep = 0;
        x_on = 1;
        wake_pulse(2, 3);            // R5 settle on 4096 xtal strobes
        idle(200);
        wake_pulse(5, 3);            // R9 wake while settling: no restart
        wait_release(5000);
        idle(3);
        wr(1, 1);                    // R7 clear status
        idle(3);
        x_on = 0;
        // R6 no delay, RC source
        wr(0, 'h125);
        #1 cpu_sleep = 1; idle(3);
        cpu_sleep = 0;
        wake_pulse(0, 2);
        idle(6);
        // R5 delay with RC strobes every third cycle
        wr(0, 'h127);
        r_on = 1;
        #1 cpu_sleep = 1; idle(3);
        cpu_sleep = 0;
        wake_pulse(7, 2);
        wait_release(200);
        idle(3);
        // R9 wake while running: status only
        wr(1, 1);
        wake_pulse(3, 2); idle(4);
        // R7 clear write held while a wake is present: set wins
        @(negedge clk); #1 wake_evt[1] = 1;
        idle(3);
        #1 wr_en = 1; wr_addr = 1; wr_data = 1;
        idle(4);
        #1 wr_en = 0; wake_evt = '0;
        idle(4);
        wr(1, 1); idle(3);
        // R2 software write with arm=1 on the wake exit edge: clear wins
        wr(0, 'h025);
        #1 cpu_sleep = 1; idle(3);
        cpu_sleep = 0;
        @(negedge clk); #1 wake_evt[4] = 1;
        idle(2);                     // synchronized wake seen in next cycle
        #1 wr_en = 1; wr_addr = 0; wr_data = 'h025;
        @(negedge clk); #1 wr_en = 0;
        wake_evt = '0;
        idle(6);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule